// File: doc/BRIEF.md
# Per-Function Mailbox with Doorbells

This block is a hardware message channel between one privileged host controller and a set of guest functions (64 by default). Every guest function owns a private 16-word message buffer and a control register. A guest access carries its function number, and that number alone selects which buffer and control register are reached. The host side reaches every function's buffer and control register as arrays indexed by function number. The host also sees an interrupt-cause vector with one bit per function.

A sender first claims the buffer by setting its ownership bit. It then writes the message and rings its doorbell, which releases ownership and interrupts the other side. The receiver reads the message and may write a reply into the same buffer with the acknowledge or negative-acknowledge flag in word 0. It can then set its own acknowledge bit, which also interrupts the opposite side. Three flag bits of word 0 are mirrored into both control-register views, so a reader can see the reply status without fetching the buffer.

Top module: `fn_mailbox`

## Requirements
- R1: A guest access reaches only the buffer word `g_addr[3:0]` and the control register (`g_addr[4]`=1) of function `g_fn`; a write by one function never changes another function's buffer.
- R2: The host reaches buffer word `h_addr[3:0]` and the control register (`h_addr[4]`=1) of function `h_fn`, for any function.
- R3: Writing a control register with bit 2 (take) set grants that side ownership of the function's buffer unless the other side already holds it. When both sides request a free buffer in the same cycle, the host wins. Control read bit 2 shows the reader's own ownership and bit 4 shows the other side's.
- R4: A buffer write from a side that does not hold ownership of that buffer is ignored.
- R5: Ownership held by a side is released when that side writes its control register with bit 0 (doorbell) or bit 3 (drop) set.
- R6: A guest doorbell (control bit 0) sets `h_cause[fn]`, and `h_irq` rises on the same clock edge; host control read bit 5 shows `h_cause[fn]`.
- R7: A host doorbell sets the guest's message-pending bit (guest control read bit 5) and raises `g_irq[fn]` on the same edge, for that function only.
- R8: Control bit 1 (acknowledge) written by the guest sets `h_cause[fn]`; written by the host, it sets the guest's acknowledge-pending bit (guest control read bit 6) and `g_irq[fn]`.
- R9: Interrupt causes are write-one-to-clear: `h_cause_clr[fn]` clears `h_cause[fn]`, and a guest control write with bit 5 or bit 6 set clears that pending bit. A new setting event in the same cycle wins over the clear. `h_irq` is the OR of `h_cause`, and `g_irq[fn]` is the OR of the guest's two pending bits.
- R10: Word 0 carries the message type in bits 15:0, an info byte in bits 23:16, ACK in bit 31, NACK in bit 30 and clear-to-send in bit 29. Both control views return the last permitted word-0 write's bits 31:29 in their bits 31:29.
- R11: A read request returns `*_rdata` with `*_rvalid` high one cycle later. A control read returns the state before any write in that same cycle.
- R12: After reset no ownership is held, and `h_cause`, `h_irq`, `g_irq` and the read-valid outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| g_req | input | 1 | Guest access request |
| g_we | input | 1 | Guest write (1) or read (0) |
| g_fn | input | 6 | Function number carried by the guest access |
| g_addr | input | 5 | Bit 4: control register; bits 3:0: buffer word |
| g_wdata | input | 32 | Guest write data |
| g_rdata | output | 32 | Guest read data |
| g_rvalid | output | 1 | Guest read data valid |
| g_irq | output | 64 | Per-function interrupt toward the guest side |
| h_req | input | 1 | Host access request |
| h_we | input | 1 | Host write (1) or read (0) |
| h_fn | input | 6 | Function index of the host access |
| h_addr | input | 5 | Bit 4: control register; bits 3:0: buffer word |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data |
| h_rvalid | output | 1 | Host read data valid |
| h_cause | output | 64 | Host interrupt-cause vector, one bit per function |
| h_cause_clr | input | 64 | Write-one-to-clear strobes for h_cause |
| h_irq | output | 1 | Host interrupt, OR of the cause vector |

## Verification
The hardest situations to reach are those where both ports act on the same function in the same cycle. Examples are two ownership requests on a free buffer, or a guest doorbell arriving as the host clears that cause bit. A sequence of single accesses never produces them. The bench therefore has a directed step that drives the guest and host ports on one falling edge, so that both land on the same rising edge. It then reads back ownership and cause through the normal control-register views. Refused ownership is also checked from the ports: the host attempts a buffer write without ownership, and the guest then reads back the original word.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // control-register bit positions (same on both sides)
  localparam int CB_BELL  = 0;
  localparam int CB_ACK   = 1;
  localparam int CB_TAKE  = 2;
  localparam int CB_DROP  = 3;
  localparam int CB_PEER  = 4;
  localparam int CB_PEND  = 5;
  localparam int CB_APEND = 6;
  // word-0 flag positions
  localparam int W0_ACK  = 31;
  localparam int W0_NACK = 30;
  localparam int W0_CTS  = 29;

  typedef struct packed {
    logic ack;
    logic nack;
    logic cts;
  } w0_flags_t;
endpackage

// File: rtl/mbx_dpram.sv
module mbx_dpram #(
  parameter int DEPTH = 1024,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  // writes of the two ports never target one buffer in one cycle (ownership)
  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      a_rdata <= mem[a_addr];
    end
    if (b_en) begin
      if (b_we) mem[b_addr] <= b_wdata;
      b_rdata <= mem[b_addr];
    end
  end
endmodule

// File: rtl/mbx_fn_ctrl.sv
module mbx_fn_ctrl
  import mbx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      g_bell,
  input  logic      g_ack,
  input  logic      g_take,
  input  logic      g_drop,
  input  logic      g_clr_pend,
  input  logic      g_clr_apend,
  input  logic      h_bell,
  input  logic      h_ack,
  input  logic      h_take,
  input  logic      h_drop,
  input  logic      h_clr,
  input  logic      g_w0_we,
  input  w0_flags_t g_w0,
  input  logic      h_w0_we,
  input  w0_flags_t h_w0,
  output logic      g_own,
  output logic      h_own,
  output logic      h_cause,
  output logic      h_cause_n,
  output logic      g_irq,
  output logic [31:0] g_view,
  output logic [31:0] h_view
);
  logic      g_own_q, h_own_q, hc_q, gp_q, ga_q, g_irq_q;
  w0_flags_t flags_q;
  logic      h_grant, g_grant;
  logic      g_own_n, h_own_n, gp_n, ga_n;

  always_comb begin
    h_grant   = h_take & ~g_own_q;
    g_grant   = g_take & ~h_own_q & ~h_grant;
    h_own_n   = (h_own_q | h_grant) & ~(h_drop | h_bell);
    g_own_n   = (g_own_q | g_grant) & ~(g_drop | g_bell);
    h_cause_n = g_bell | g_ack | (hc_q & ~h_clr);
    gp_n      = h_bell | (gp_q & ~g_clr_pend);
    ga_n      = h_ack  | (ga_q & ~g_clr_apend);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      g_own_q <= 1'b0;
      h_own_q <= 1'b0;
      hc_q    <= 1'b0;
      gp_q    <= 1'b0;
      ga_q    <= 1'b0;
      g_irq_q <= 1'b0;
      flags_q <= '0;
    end else begin
      g_own_q <= g_own_n;
      h_own_q <= h_own_n;
      hc_q    <= h_cause_n;
      gp_q    <= gp_n;
      ga_q    <= ga_n;
      g_irq_q <= gp_n | ga_n;
      if (g_w0_we)      flags_q <= g_w0;
      else if (h_w0_we) flags_q <= h_w0;
    end
  end

  always_comb begin
    g_view            = '0;
    g_view[W0_ACK]    = flags_q.ack;
    g_view[W0_NACK]   = flags_q.nack;
    g_view[W0_CTS]    = flags_q.cts;
    h_view            = g_view;
    g_view[CB_TAKE]   = g_own_q;
    g_view[CB_PEER]   = h_own_q;
    g_view[CB_PEND]   = gp_q;
    g_view[CB_APEND]  = ga_q;
    h_view[CB_TAKE]   = h_own_q;
    h_view[CB_PEER]   = g_own_q;
    h_view[CB_PEND]   = hc_q;
  end

  assign g_own   = g_own_q;
  assign h_own   = h_own_q;
  assign h_cause = hc_q;
  assign g_irq   = g_irq_q;
endmodule

// File: rtl/fn_mailbox.sv
module fn_mailbox
  import mbx_pkg::*;
#(
  parameter int NUM_FN = 64,
  parameter int WORDS  = 16,
  parameter int DW     = 32,
  localparam int FN_W  = $clog2(NUM_FN),
  localparam int IDX_W = $clog2(WORDS),
  localparam int AW    = IDX_W + 1,
  localparam int MA_W  = FN_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              g_req,
  input  logic              g_we,
  input  logic [FN_W-1:0]   g_fn,
  input  logic [AW-1:0]     g_addr,
  input  logic [DW-1:0]     g_wdata,
  output logic [DW-1:0]     g_rdata,
  output logic              g_rvalid,
  output logic [NUM_FN-1:0] g_irq,
  input  logic              h_req,
  input  logic              h_we,
  input  logic [FN_W-1:0]   h_fn,
  input  logic [AW-1:0]     h_addr,
  input  logic [DW-1:0]     h_wdata,
  output logic [DW-1:0]     h_rdata,
  output logic              h_rvalid,
  output logic [NUM_FN-1:0] h_cause,
  input  logic [NUM_FN-1:0] h_cause_clr,
  output logic              h_irq
);
  logic g_ok, h_ok;

  generate
    if (NUM_FN == (1 << FN_W)) begin : g_full
      assign g_ok = g_req;
      assign h_ok = h_req;
    end else begin : g_part
      assign g_ok = g_req & (int'(g_fn) < NUM_FN);
      assign h_ok = h_req & (int'(h_fn) < NUM_FN);
    end
  endgenerate

  logic [NUM_FN-1:0] g_own_v, h_own_v, h_cause_n;
  logic [31:0]       g_view_a [NUM_FN];
  logic [31:0]       h_view_a [NUM_FN];

  logic g_is_ctl, h_is_ctl, g_buf_wr, h_buf_wr, g_ram_en, h_ram_en;
  logic g_ctl_wr, h_ctl_wr, g_w0_hit, h_w0_hit;

  always_comb begin
    g_is_ctl = g_addr[AW-1];
    h_is_ctl = h_addr[AW-1];
    g_buf_wr = g_ok & g_we & ~g_is_ctl & g_own_v[g_fn];
    h_buf_wr = h_ok & h_we & ~h_is_ctl & h_own_v[h_fn];
    g_ram_en = g_ok & ~g_is_ctl & (~g_we | g_buf_wr);
    h_ram_en = h_ok & ~h_is_ctl & (~h_we | h_buf_wr);
    g_ctl_wr = g_ok & g_we & g_is_ctl;
    h_ctl_wr = h_ok & h_we & h_is_ctl;
    g_w0_hit = g_buf_wr & (g_addr[IDX_W-1:0] == '0);
    h_w0_hit = h_buf_wr & (h_addr[IDX_W-1:0] == '0);
  end

  w0_flags_t g_w0, h_w0;
  assign g_w0 = '{ack: g_wdata[W0_ACK], nack: g_wdata[W0_NACK], cts: g_wdata[W0_CTS]};
  assign h_w0 = '{ack: h_wdata[W0_ACK], nack: h_wdata[W0_NACK], cts: h_wdata[W0_CTS]};

  logic [DW-1:0] g_ram_q, h_ram_q;

  mbx_dpram #(.DEPTH(NUM_FN * WORDS), .DW(DW)) u_ram (
    .clk     (clk),
    .a_en    (g_ram_en),
    .a_we    (g_buf_wr),
    .a_addr  (MA_W'({g_fn, g_addr[IDX_W-1:0]})),
    .a_wdata (g_wdata),
    .a_rdata (g_ram_q),
    .b_en    (h_ram_en),
    .b_we    (h_buf_wr),
    .b_addr  (MA_W'({h_fn, h_addr[IDX_W-1:0]})),
    .b_wdata (h_wdata),
    .b_rdata (h_ram_q)
  );

  for (genvar i = 0; i < NUM_FN; i++) begin : g_fn_slot
    logic g_sel, h_sel;
    assign g_sel = g_ctl_wr & (g_fn == FN_W'(i));
    assign h_sel = h_ctl_wr & (h_fn == FN_W'(i));

    mbx_fn_ctrl u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .g_bell      (g_sel & g_wdata[CB_BELL]),
      .g_ack       (g_sel & g_wdata[CB_ACK]),
      .g_take      (g_sel & g_wdata[CB_TAKE]),
      .g_drop      (g_sel & g_wdata[CB_DROP]),
      .g_clr_pend  (g_sel & g_wdata[CB_PEND]),
      .g_clr_apend (g_sel & g_wdata[CB_APEND]),
      .h_bell      (h_sel & h_wdata[CB_BELL]),
      .h_ack       (h_sel & h_wdata[CB_ACK]),
      .h_take      (h_sel & h_wdata[CB_TAKE]),
      .h_drop      (h_sel & h_wdata[CB_DROP]),
      .h_clr       (h_cause_clr[i]),
      .g_w0_we     (g_w0_hit & (g_fn == FN_W'(i))),
      .g_w0        (g_w0),
      .h_w0_we     (h_w0_hit & (h_fn == FN_W'(i))),
      .h_w0        (h_w0),
      .g_own       (g_own_v[i]),
      .h_own       (h_own_v[i]),
      .h_cause     (h_cause[i]),
      .h_cause_n   (h_cause_n[i]),
      .g_irq       (g_irq[i]),
      .g_view      (g_view_a[i]),
      .h_view      (h_view_a[i])
    );
  end

  // read return path: one register stage for both buffer and control
  logic        g_ctl_sel_q, h_ctl_sel_q;
  logic [31:0] g_ctl_q, h_ctl_q;
  logic        h_irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      g_rvalid    <= 1'b0;
      h_rvalid    <= 1'b0;
      g_ctl_sel_q <= 1'b0;
      h_ctl_sel_q <= 1'b0;
      g_ctl_q     <= '0;
      h_ctl_q     <= '0;
      h_irq_q     <= 1'b0;
    end else begin
      g_rvalid    <= g_ok & ~g_we;
      h_rvalid    <= h_ok & ~h_we;
      g_ctl_sel_q <= g_is_ctl;
      h_ctl_sel_q <= h_is_ctl;
      if (g_ok & ~g_we & g_is_ctl) g_ctl_q <= g_view_a[g_fn];
      if (h_ok & ~h_we & h_is_ctl) h_ctl_q <= h_view_a[h_fn];
      h_irq_q     <= |h_cause_n;
    end
  end

  assign g_rdata = g_ctl_sel_q ? DW'(g_ctl_q) : g_ram_q;
  assign h_rdata = h_ctl_sel_q ? DW'(h_ctl_q) : h_ram_q;
  assign h_irq   = h_irq_q;
endmodule

// File: rtl/fn_mailbox_chk.sv
module fn_mailbox_chk #(
  parameter int NUM_FN = 64,
  parameter int AW     = 5,
  parameter int FN_W   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              g_req,
  input logic              g_we,
  input logic [FN_W-1:0]   g_fn,
  input logic [AW-1:0]     g_addr,
  input logic [31:0]       g_wdata,
  input logic              g_rvalid,
  input logic              h_req,
  input logic              h_we,
  input logic              h_rvalid,
  input logic              h_irq,
  input logic [NUM_FN-1:0] h_cause,
  input logic [NUM_FN-1:0] g_own_v,
  input logic [NUM_FN-1:0] h_own_v
);
  // R3
  excl_own_chk: assert property (@(posedge clk) disable iff (rst)
    (g_own_v & h_own_v) == '0);

  // R11
  g_rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (g_req && !g_we) |=> g_rvalid);

  // R11
  h_rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (h_req && !h_we) |=> h_rvalid);

  // R6
  g_bell_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (g_req && g_we && g_addr[AW-1] && g_wdata[0]) |=> (h_irq && h_cause[g_fn_q]));

  // R9
  irq_or_chk: assert property (@(posedge clk) disable iff (rst)
    h_irq == (|h_cause));

  // R12
  rst_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (h_cause == '0 && !h_irq && !g_rvalid && !h_rvalid && g_own_v == '0));

  logic [FN_W-1:0] g_fn_q;
  always_ff @(posedge clk) g_fn_q <= g_fn;
endmodule

bind fn_mailbox fn_mailbox_chk #(.NUM_FN(NUM_FN), .AW(AW), .FN_W(FN_W)) u_fn_mailbox_chk (
  .clk      (clk),
  .rst      (rst),
  .g_req    (g_req),
  .g_we     (g_we),
  .g_fn     (g_fn),
  .g_addr   (g_addr),
  .g_wdata  (g_wdata),
  .g_rvalid (g_rvalid),
  .h_req    (h_req),
  .h_we     (h_we),
  .h_rvalid (h_rvalid),
  .h_irq    (h_irq),
  .h_cause  (h_cause),
  .g_own_v  (g_own_v),
  .h_own_v  (h_own_v)
);

// File: tb/test_fn_mailbox.sv
`timescale 1ns/1ps
module test_fn_mailbox;
  localparam int NF = 64;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic g_req = 0, g_we = 0, h_req = 0, h_we = 0;
  logic [5:0] g_fn = 0, h_fn = 0;
  logic [4:0] g_addr = 0, h_addr = 0;
  logic [31:0] g_wdata = 0, h_wdata = 0, g_rdata, h_rdata;
  logic g_rvalid, h_rvalid, h_irq;
  logic [NF-1:0] g_irq, h_cause, h_cause_clr = '0;

  fn_mailbox i_fn_mailbox (
    .clk(clk), .rst(rst),
    .g_req(g_req), .g_we(g_we), .g_fn(g_fn), .g_addr(g_addr), .g_wdata(g_wdata),
    .g_rdata(g_rdata), .g_rvalid(g_rvalid), .g_irq(g_irq),
    .h_req(h_req), .h_we(h_we), .h_fn(h_fn), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_rvalid(h_rvalid), .h_cause(h_cause),
    .h_cause_clr(h_cause_clr), .h_irq(h_irq)
  );

  int nchk = 0, nbad = 0;
  bit done = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic side, input logic we, input logic [5:0] fn,
                    input logic [4:0] addr, input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    if (side) begin h_req = 1; h_we = we; h_fn = fn; h_addr = addr; h_wdata = wd; end
    else      begin g_req = 1; g_we = we; g_fn = fn; g_addr = addr; g_wdata = wd; end
    @(negedge clk);
    g_req = 0; h_req = 0;
    rd = side ? h_rdata : g_rdata;
  endtask

  localparam logic G = 1'b0, H = 1'b1, W = 1'b1, R = 1'b0;
  localparam logic [4:0] C = 5'h10;
  // {req[3:0], side, we, fn[5:0], addr[4:0], wdata[31:0], expected[31:0]}
  localparam int NV = 24;
  localparam logic [80:0] VEC [NV] = '{
    {4'd3,  G, W, 6'd3, C,     32'h0000_0004, 32'h0},           // R3 guest take
    {4'd3,  G, R, 6'd3, C,     32'h0,         32'h0000_0004},   // R3 guest owns
    {4'd10, G, W, 6'd3, 5'h0,  32'h2012_0007, 32'h0},           // R10 word 0 with CTS
    {4'd1,  G, W, 6'd3, 5'h1,  32'hDEAD_BEEF, 32'h0},
    {4'd1,  G, R, 6'd3, 5'h1,  32'h0,         32'hDEAD_BEEF},   // R1
    {4'd10, H, R, 6'd3, C,     32'h0,         32'h2000_0010},   // R10 flags, peer owns
    {4'd3,  H, W, 6'd3, C,     32'h0000_0004, 32'h0},           // R3 refused take
    {4'd3,  H, R, 6'd3, C,     32'h0,         32'h2000_0010},
    {4'd4,  H, W, 6'd3, 5'h1,  32'h1111_1111, 32'h0},           // R4 write ignored
    {4'd4,  G, R, 6'd3, 5'h1,  32'h0,         32'hDEAD_BEEF},
    {4'd1,  G, W, 6'd4, C,     32'h0000_0004, 32'h0},
    {4'd1,  G, W, 6'd4, 5'h1,  32'h4444_4444, 32'h0},
    {4'd1,  G, R, 6'd4, 5'h1,  32'h0,         32'h4444_4444},
    {4'd1,  G, R, 6'd3, 5'h1,  32'h0,         32'hDEAD_BEEF},   // R1 isolation
    {4'd6,  G, W, 6'd3, C,     32'h0000_0001, 32'h0},           // R6 guest doorbell
    {4'd5,  H, R, 6'd3, C,     32'h0,         32'h2000_0020},   // R5 released, R6 cause
    {4'd2,  H, R, 6'd3, 5'h0,  32'h0,         32'h2012_0007},   // R2
    {4'd3,  H, W, 6'd3, C,     32'h0000_0004, 32'h0},
    {4'd10, H, W, 6'd3, 5'h0,  32'h8012_0007, 32'h0},           // reply flagged ACK
    {4'd8,  H, W, 6'd3, C,     32'h0000_000A, 32'h0},           // R8 host ack + drop
    {4'd8,  G, R, 6'd3, C,     32'h0,         32'h8000_0040},   // R8, R10
    {4'd2,  H, R, 6'd4, C,     32'h0,         32'h0000_0010},   // R2
    {4'd5,  G, W, 6'd4, C,     32'h0000_0008, 32'h0},           // R5 explicit drop
    {4'd2,  H, R, 6'd4, 5'h1,  32'h0,         32'h4444_4444}    // R2
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    check("R12 h_cause", 64'(h_cause), 64'h0);
    check("R12 irqs", {62'h0, h_irq, |g_irq}, 64'h0);
    check("R12 rvalid", {62'h0, g_rvalid, h_rvalid}, 64'h0);

    for (int v = 0; v < NV; v++) begin
      op(VEC[v][76], VEC[v][75], VEC[v][74:69], VEC[v][68:64], VEC[v][63:32], rd);
      if (!VEC[v][75]) begin
        nchk++;
        if (rd !== VEC[v][31:0]) begin
          nbad++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[v][80:77], v, rd, VEC[v][31:0]);
        end
      end
    end

    // R6 cause from the doorbell, R9 clear
    check("R6 h_cause", 64'(h_cause), 64'h8);
    check("R6 h_irq", 64'(h_irq), 64'h1);
    @(negedge clk); h_cause_clr[3] = 1'b1;
    @(negedge clk); h_cause_clr = '0;
    check("R9 h_cause cleared", 64'(h_cause), 64'h0);
    check("R9 h_irq low", 64'(h_irq), 64'h0);
    // R8 host ack reached guest 3; R9 guest clears it
    check("R8 g_irq", 64'(g_irq), 64'h8);
    op(G, W, 6'd3, C, 32'h0000_0040, rd);
    check("R9 g_irq cleared", 64'(g_irq), 64'h0);

    // R7 host posts to function 7 with NACK
    op(H, W, 6'd7, C, 32'h4, rd);
    op(H, W, 6'd7, 5'h0, 32'h4000_0001, rd);
    op(H, W, 6'd7, C, 32'h1, rd);
    check("R7 g_irq only fn7", 64'(g_irq), 64'h80);
    op(G, R, 6'd7, C, 32'h0, rd);
    check("R7 R10 guest view", 64'(rd), 64'h4000_0020);
    // R8 guest ack interrupts host
    op(G, W, 6'd7, C, 32'h2, rd);
    check("R8 h_cause fn7", 64'(h_cause), 64'h80);
    check("R8 h_irq", 64'(h_irq), 64'h1);

    // R11 latency of a read
    @(negedge clk); g_req = 1; g_we = 0; g_fn = 6'd4; g_addr = 5'h1;
    @(negedge clk); g_req = 0;
    check("R11 rvalid", 64'(g_rvalid), 64'h1);
    check("R11 rdata", 64'(g_rdata), 64'h4444_4444);
    @(negedge clk);
    check("R11 rvalid drops", 64'(g_rvalid), 64'h0);

    // R3 tie on a free buffer: host wins
    @(negedge clk);
    g_req = 1; g_we = 1; g_fn = 6'd9; g_addr = C; g_wdata = 32'h4;
    h_req = 1; h_we = 1; h_fn = 6'd9; h_addr = C; h_wdata = 32'h4;
    @(negedge clk); g_req = 0; h_req = 0;
    op(H, R, 6'd9, C, 32'h0, rd);
    check("R3 tie host view", 64'(rd), 64'h4);
    op(G, R, 6'd9, C, 32'h0, rd);
    check("R3 tie guest view", 64'(rd), 64'h10);
    // R5 explicit drop then guest may take
    op(H, W, 6'd9, C, 32'h8, rd);
    op(G, W, 6'd9, C, 32'h4, rd);
    op(G, R, 6'd9, C, 32'h0, rd);
    check("R5 guest takes after drop", 64'(rd), 64'h4);

    // R9 set wins over clear in the same cycle
    @(negedge clk); h_cause_clr = '1;
    @(negedge clk);
    g_req = 1; g_we = 1; g_fn = 6'd9; g_addr = C; g_wdata = 32'h1;
    @(negedge clk); g_req = 0; h_cause_clr = '0;
    check("R9 set wins", 64'(h_cause), 64'h200);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule